// File: doc/BRIEF.md
# Register Auto-Modification Tracker

This block keeps a record of the general registers that the current instruction has stepped up or down through its addressing modes, together with the signed amount of each step. When an instruction is aborted part-way, recovery software reads the record and undoes the register changes before it restarts the instruction.

The CPU reports each register step on an event port. The port carries a 3-bit register number, a signed 5-bit amount and a valid strobe. The block stores at most two such records in a 16-bit value that software can read.

The record is cleared when a new instruction begins. It stops changing as soon as any of the three abort flags in the address-translation status register is set. This includes a flag that software sets by writing the status register itself, so the frozen value then shows the steps made by that writing instruction.

A small state machine controls the storage. It has four states:

- EMPTY: no record held.
- ONE: the low byte holds a record.
- FULL: both bytes are in use, or the record is being held after a freeze.
- FROZEN: at least one abort flag is set.

Its transitions are:

- record-first: EMPTY to ONE on an accepted event.
- record-second: ONE to FULL on an accepted event.
- restart: ONE, FULL or FROZEN to EMPTY, or to ONE when an event comes in the same cycle, when an instruction starts with no flag set.
- freeze: any state to FROZEN while a flag is set.
- release: FROZEN to FULL when the flags clear with no instruction start.

Top module: `reg_mod_tracker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the 16-bit record reads zero.
- R2: The first accepted event is written into bits 7:0 of the record, with the register number in bits 2:0 and the signed amount in bits 7:3 as two's complement. A word step is written as +2 (00010) or -2 (11110), a byte step as +1 (00001) or -1 (11111), and a program-counter step as register 7. Bits 15:8 stay zero.
- R3: The second accepted event of the same instruction is written into bits 15:8 in the same layout (number in 10:8, amount in 15:11). Bits 7:0 do not change.
- R4: Events that arrive after two records are held are dropped, and the record does not change.
- R5: Two events for the same register occupy separate bytes. Their amounts are not added together.
- R6: An instruction-start pulse with all abort flags clear sets the record to zero. An event in the same cycle becomes the new first record.
- R7: While any of the three abort flags is set, the record does not change. Events and instruction-start pulses have no effect.
- R8: When the flags clear, the frozen record is kept, and events are dropped until the next instruction-start pulse.
- R9: An event or pulse presented before a rising edge is visible at the output right after that edge, one register stage in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_start | input | 1 | Pulse marking the fetch of a new instruction |
| upd_valid | input | 1 | A register step is reported this cycle |
| upd_reg | input | 3 | Number of the stepped register |
| upd_delta | input | 5 | Signed step amount |
| abort_flags | input | 3 | Abort flags of the translation status register |
| track_value | output | 16 | Readable record: second record in bits 15:8, first in bits 7:0 |

## Verification
A wrong state shows at the port within one cycle:

- A state machine left in ONE when it should be in FULL lets a third event overwrite the high byte.
- A state machine that leaves FROZEN too early lets an event or a start pulse change a value that recovery software depends on.
- Swapped or summed records show up as a wrong byte in the next read.

The scoreboard compares every cycle of each scenario against a value worked out by hand. Any of these faults is therefore reported at the first edge where it takes effect.

// File: rtl/trk_pkg.sv
package trk_pkg;
    localparam int REG_W   = 3;
    localparam int DELTA_W = 5;
    localparam int FLAG_N  = 3;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_ONE    = 2'd1,
        ST_FULL   = 2'd2,
        ST_FROZEN = 2'd3
    } trk_state_e;
endpackage

// File: rtl/trk_fsm.sv
module trk_fsm
    import trk_pkg::*;
#(
    parameter int FLAGS = FLAG_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_start,
    input  logic             upd_valid,
    input  logic [FLAGS-1:0] abort_flags,
    output trk_state_e       state_q,
    output logic             clr,
    output logic             wr_lo,
    output logic             wr_hi
);
    trk_state_e state_d;
    logic       freeze;

    assign freeze = |abort_flags;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // next state and strobes
    always_comb begin
        state_d = state_q;
        clr     = 1'b0;
        wr_lo   = 1'b0;
        wr_hi   = 1'b0;
        if (freeze) begin
            state_d = ST_FROZEN;
        end else if (instr_start) begin
            clr     = 1'b1;
            wr_lo   = upd_valid;
            state_d = upd_valid ? ST_ONE : ST_EMPTY;
        end else begin
            unique case (state_q)
                ST_EMPTY: begin
                    wr_lo = upd_valid;
                    if (upd_valid) state_d = ST_ONE;
                end
                ST_ONE: begin
                    wr_hi = upd_valid;
                    if (upd_valid) state_d = ST_FULL;
                end
                ST_FULL:   state_d = ST_FULL;
                ST_FROZEN: state_d = ST_FULL;
            endcase
        end
    end
endmodule

// File: rtl/trk_store.sv
module trk_store #(
    parameter int RW = 3,
    parameter int DW = 5,
    localparam int BW = RW + DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [RW-1:0] rnum,
    input  logic [DW-1:0] delta,
    output logic [2*BW-1:0] value
);
    logic [BW-1:0] lo_q, hi_q, rec;

    assign rec   = {delta, rnum};
    assign value = {hi_q, lo_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (clr) begin
            lo_q <= wr_lo ? rec : '0;
            hi_q <= '0;
        end else begin
            if (wr_lo) lo_q <= rec;
            if (wr_hi) hi_q <= rec;
        end
    end
endmodule

// File: rtl/reg_mod_tracker.sv
module reg_mod_tracker
    import trk_pkg::*;
#(
    parameter int RW    = REG_W,
    parameter int DW    = DELTA_W,
    parameter int FLAGS = FLAG_N,
    localparam int OW   = 2 * (RW + DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_start,
    input  logic             upd_valid,
    input  logic [RW-1:0]    upd_reg,
    input  logic [DW-1:0]    upd_delta,
    input  logic [FLAGS-1:0] abort_flags,
    output logic [OW-1:0]    track_value
);
    trk_state_e state_q;
    logic       clr, wr_lo, wr_hi;

    trk_fsm #(.FLAGS(FLAGS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .instr_start(instr_start),
        .upd_valid(upd_valid), .abort_flags(abort_flags),
        .state_q(state_q), .clr(clr), .wr_lo(wr_lo), .wr_hi(wr_hi)
    );

    trk_store #(.RW(RW), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .rnum(upd_reg), .delta(upd_delta), .value(track_value)
    );
endmodule

// File: rtl/reg_mod_tracker_chk.sv
module reg_mod_tracker_chk
    import trk_pkg::*;
#(
    parameter int RW    = REG_W,
    parameter int DW    = DELTA_W,
    parameter int FLAGS = FLAG_N,
    localparam int BW   = RW + DW
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_start,
    input logic             upd_valid,
    input logic [RW-1:0]    upd_reg,
    input logic [DW-1:0]    upd_delta,
    input logic [FLAGS-1:0] abort_flags,
    input logic [2*BW-1:0]  track_value,
    input trk_state_e       st
);
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> track_value == '0);

    assert_first_record_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_flags == '0 && instr_start && upd_valid)
        |=> track_value == {{BW{1'b0}}, $past(upd_delta), $past(upd_reg)});

    assert_low_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_flags == '0 && !instr_start && st == ST_ONE)
        |=> $stable(track_value[BW-1:0]));

    assert_drop_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_flags == '0 && !instr_start && st == ST_FULL)
        |=> $stable(track_value));

    assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_flags == '0 && instr_start && !upd_valid) |=> track_value == '0);

    assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_flags != '0) |=> ($stable(track_value) && st == ST_FROZEN));

    assert_release_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FROZEN && abort_flags == '0 && !instr_start) |=> st == ST_FULL);
endmodule

bind reg_mod_tracker reg_mod_tracker_chk #(.RW(RW), .DW(DW), .FLAGS(FLAGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .instr_start(instr_start), .upd_valid(upd_valid),
    .upd_reg(upd_reg), .upd_delta(upd_delta), .abort_flags(abort_flags),
    .track_value(track_value), .st(state_q)
);

// File: tb/reg_mod_tracker_bench.sv
`timescale 1ns/1ps
module reg_mod_tracker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_start = 1'b0;
    logic        upd_valid = 1'b0;
    logic [2:0]  upd_reg = '0;
    logic [4:0]  upd_delta = '0;
    logic [2:0]  abort_flags = '0;
    logic [15:0] track_value;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    reg_mod_tracker u_reg_mod_tracker (
        .clk(clk), .rst_n(rst_n), .instr_start(instr_start), .upd_valid(upd_valid),
        .upd_reg(upd_reg), .upd_delta(upd_delta), .abort_flags(abort_flags),
        .track_value(track_value)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and queue the value due after the edge
    task automatic step(input logic st, input logic v, input logic [2:0] r,
                        input logic [4:0] d, input logic [2:0] ab,
                        input logic [15:0] exp, input string tag);
        @(negedge clk);
        instr_start = st; upd_valid = v; upd_reg = r; upd_delta = d; abort_flags = ab;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk);
    endtask

    // monitor: sample one ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) check(track_value, exp_q.pop_front(), tag_q.pop_front());
    end

    initial begin
        #200000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check(track_value, 16'h0000, "R1 during reset");
        @(negedge clk); rst_n = 1'b1;
        step(1, 1, 3'd1, 5'b00010, 3'b000, 16'h0011, "R6 R2 start+r1 +2");
        step(0, 1, 3'd2, 5'b00010, 3'b000, 16'h1211, "R3 second r2 +2");
        step(0, 1, 3'd3, 5'b11110, 3'b000, 16'h1211, "R4 third dropped");
        step(1, 0, 3'd0, 5'b00000, 3'b000, 16'h0000, "R6 start clears");
        step(0, 1, 3'd4, 5'b11111, 3'b000, 16'h00FC, "R2 r4 -1");
        step(0, 1, 3'd4, 5'b11111, 3'b000, 16'hFCFC, "R5 same reg twice");
        step(1, 1, 3'd7, 5'b00010, 3'b000, 16'h0017, "R2 pc +2");
        step(0, 1, 3'd1, 5'b11110, 3'b000, 16'hF117, "R3 r1 -2");
        step(1, 0, 3'd0, 5'b00000, 3'b001, 16'hF117, "R7 start under abort");
        step(0, 1, 3'd5, 5'b00001, 3'b010, 16'hF117, "R7 event under abort");
        step(0, 0, 3'd0, 5'b00000, 3'b000, 16'hF117, "R8 release keeps");
        step(0, 1, 3'd2, 5'b00010, 3'b000, 16'hF117, "R8 event after release");
        step(1, 0, 3'd0, 5'b00000, 3'b000, 16'h0000, "R6 start after release");
        step(0, 1, 3'd0, 5'b00001, 3'b000, 16'h0008, "R2 r0 +1");
        step(0, 1, 3'd3, 5'b00010, 3'b100, 16'h0008, "R7 flag2 freezes one record");
        step(0, 1, 3'd3, 5'b00010, 3'b000, 16'h0008, "R8 dropped until start");
        step(1, 1, 3'd6, 5'b11110, 3'b000, 16'h00F6, "R6 start+r6 -2");
        // R9: before the next edge the output still shows the old value
        @(negedge clk);
        instr_start = 1'b0; upd_valid = 1'b1; upd_reg = 3'd5; upd_delta = 5'b00001;
        #1 check(track_value, 16'h00F6, "R9 not before edge");
        exp_q.push_back(16'h0DF6); tag_q.push_back("R9 after edge");
        @(posedge clk);
        @(negedge clk); upd_valid = 1'b0; rst_n = 1'b0;
        @(posedge clk); #1 check(track_value, 16'h0000, "R1 reset mid-run");
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule